// File: doc/BRIEF.md
# Scanline Timing and Status Generator

This block paces a display by counting master clock cycles across each scanline and scanlines across each frame. From those two counters it derives three status flags (horizontal blank, vertical blank and a programmable line match) and turns their rising events into single-cycle interrupt request pulses. Downstream logic such as renderers, DMA engines and an interrupt controller consume these flags and pulses.

Two processors share the display and each owns a separate copy of the status word. Each copy holds its own interrupt enables and its own 9-bit line-compare value, so both processors can watch different lines and enable different events. A third write target lets software overwrite the line counter. The new value is held back and takes effect at the next line start. A frame-end pulse marks the moment the last line has finished, so that a double-buffer swap can be timed from it.

Top module: `scan_timing_gen`

## Requirements
- R1: After reset both status words read 0, the line counter reads 0, all interrupt pulses and the frame-end pulse are low, and no line-counter write is pending.
- R2: Each line lasts LINE_CYCLES clocks. The line counter steps by one at each line start and returns to 0 after line FRAME_LINES-1 (262 by default).
- R3: Status bit 1 (hblank) rises HBLANK_START clocks after a line starts and is cleared at the next line start.
- R4: Status bit 0 (vblank) is set when a line start enters line VBLANK_LINE (192) and is cleared when a line start enters line FRAME_LINES-1.
- R5: The compare value of each copy is {status[7], status[15:8]} with bit 7 as the ninth bit. At every line start, status bit 2 is set if the new line number equals it and cleared otherwise.
- R6: Each copy has its own one-cycle requests. vblank_irq is gated by status bit 3, hblank_irq by bit 4 and vmatch_irq by bit 5. Each request is raised in the cycle its flag is set. Index 0 of each request vector belongs to copy 0.
- R7: Write address 0 targets copy 0 and address 1 targets copy 1. A write replaces only the bits under 16'hFFB8 and keeps the bits under 16'h0047. Address 3 changes nothing.
- R8: A write to address 2 stores wr_data[8:0] as pending. At the next line start the pending value is loaded instead of the increment, and the line counter keeps its value until then.
- R9: A line start that leaves the last line always loads 0 and discards any pending line-counter write.
- R10: frame_end is high for exactly the first cycle of line 0 that follows the completion of the last line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0: status copy 0, 1: status copy 1, 2: line counter, 3: none |
| wr_data | input | 16 | Write data |
| stat0 | output | 16 | Status word of copy 0 |
| stat1 | output | 16 | Status word of copy 1 |
| vcount | output | 9 | Current line number |
| hblank_irq | output | 2 | Per-copy hblank request pulse |
| vblank_irq | output | 2 | Per-copy vblank request pulse |
| vmatch_irq | output | 2 | Per-copy line-match request pulse |
| frame_end | output | 1 | One-cycle end-of-frame pulse |

## Verification
A cycle counter that is out by one is visible on the next line start, where vcount steps early or late and the hblank bit rises at the wrong offset. A wrong frame length only appears at the wrap, where frame_end and the vblank edges land on the wrong lines. The status words, the line counter and the pulses are sampled on every cycle of a full frame, so any drift is seen within one line. A corrupted pending register is visible one line start after the write, because vcount takes the wrong value or fails to take the held one. Random status writes placed mid-line show masking faults on the very next cycle.

// File: rtl/scan_timing_gen.sv
module scan_timing_gen #(
  parameter int LINE_CYCLES  = 2130,
  parameter int HBLANK_START = 1584,
  parameter int FRAME_LINES  = 263,
  parameter int VBLANK_LINE  = 192
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  output logic [15:0] stat0,
  output logic [15:0] stat1,
  output logic [8:0]  vcount,
  output logic [1:0]  hblank_irq,
  output logic [1:0]  vblank_irq,
  output logic [1:0]  vmatch_irq,
  output logic        frame_end
);
  localparam int HW = $clog2(LINE_CYCLES);
  localparam int LAST_LINE = FRAME_LINES - 1;
  localparam logic [15:0] WR_MASK = 16'hFFB8;
  localparam logic [15:0] RO_MASK = 16'h0047;

  logic [HW-1:0] hcnt;
  logic [8:0]    vcnt, pend_val, v_next;
  logic          pend_vld, fe_q;
  logic [15:0]   st [2];

  wire line_end   = hcnt == HW'(LINE_CYCLES - 1);
  wire hb_evt     = hcnt == HW'(HBLANK_START - 1);
  wire frame_wrap = vcnt == 9'(LAST_LINE);
  wire wr_line    = wr_en && wr_addr == 2'd2;

  assign v_next = frame_wrap ? 9'd0 : pend_vld ? pend_val : vcnt + 9'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt     <= '0;
      vcnt     <= '0;
      pend_vld <= 1'b0;
      pend_val <= '0;
      fe_q     <= 1'b0;
    end else begin
      hcnt <= line_end ? '0 : hcnt + HW'(1);
      fe_q <= line_end && frame_wrap;
      if (line_end) vcnt <= v_next;
      if (wr_line) begin
        pend_vld <= 1'b1;
        pend_val <= wr_data[8:0];
      end else if (line_end) begin
        pend_vld <= 1'b0;
      end
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_copy
    logic [15:0] st_q, st_nx;
    logic        hb_q, vb_q, vm_q;
    wire  [8:0]  cmp   = {st_q[7], st_q[15:8]};
    wire         wr_me = wr_en && wr_addr == 2'(i);
    wire         hit   = v_next == cmp;

    always_comb begin
      st_nx = wr_me ? ((st_q & RO_MASK) | (wr_data & WR_MASK)) : st_q;
      if (hb_evt) st_nx[1] = 1'b1;
      if (line_end) begin
        st_nx[1] = 1'b0;
        st_nx[2] = hit;
        if (v_next == 9'(VBLANK_LINE)) st_nx[0] = 1'b1;
        else if (v_next == 9'(LAST_LINE)) st_nx[0] = 1'b0;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q <= '0;
        hb_q <= 1'b0;
        vb_q <= 1'b0;
        vm_q <= 1'b0;
      end else begin
        st_q <= st_nx;
        hb_q <= hb_evt && st_q[4];
        vb_q <= line_end && v_next == 9'(VBLANK_LINE) && st_q[3];
        vm_q <= line_end && hit && st_q[5];
      end
    end

    assign st[i]         = st_q;
    assign hblank_irq[i] = hb_q;
    assign vblank_irq[i] = vb_q;
    assign vmatch_irq[i] = vm_q;
  end

  assign stat0     = st[0];
  assign stat1     = st[1];
  assign vcount    = vcnt;
  assign frame_end = fe_q;
endmodule

module scan_timing_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] st0_lo,
  input logic [8:0] vcount,
  input logic [1:0] hblank_irq,
  input logic [1:0] vblank_irq,
  input logic [1:0] vmatch_irq,
  input logic       frame_end
);
  a_r3_hblank_low_on_new_line: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(vcount) |-> !st0_lo[1]);
  a_r6_hblank_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank_irq != 2'b00) |=> (hblank_irq == 2'b00));
  a_r6_vblank_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_irq != 2'b00) |=> (vblank_irq == 2'b00));
  a_r6_vmatch_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (vmatch_irq != 2'b00) |=> (vmatch_irq == 2'b00));
  a_r6_hblank_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_irq[0] |-> $past(st0_lo[4]) && st0_lo[1]);
  a_r4_vblank_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_irq[0] |-> $past(st0_lo[3]) && st0_lo[0] && vcount == 9'd192);
  a_r5_vmatch_irq_flag: assert property (@(posedge clk) disable iff (!rst_n)
    vmatch_irq[0] |-> $past(st0_lo[5]) && st0_lo[2]);
  a_r10_frame_end_line0: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> vcount == 9'd0 && !st0_lo[0]);
  a_r10_frame_end_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !frame_end);
endmodule

bind scan_timing_gen scan_timing_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st0_lo(stat0[5:0]), .vcount(vcount),
  .hblank_irq(hblank_irq), .vblank_irq(vblank_irq), .vmatch_irq(vmatch_irq),
  .frame_end(frame_end)
);

// File: tb/tb_scan_timing_gen.sv
`timescale 1ns/100ps
module tb_scan_timing_gen;
  localparam int L = 20;
  localparam int HB = 14;
  localparam int FL = 263;
  localparam int FRAME = L * FL;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] stat0, stat1;
  logic [8:0]  vcount;
  logic [1:0]  hblank_irq, vblank_irq, vmatch_irq;
  logic        frame_end;

  int total = 0;
  int fails = 0;
  int n = 0;

  always #2.5 clk = ~clk;

  scan_timing_gen #(.LINE_CYCLES(L), .HBLANK_START(HB)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .stat0(stat0), .stat1(stat1), .vcount(vcount), .hblank_irq(hblank_irq),
    .vblank_irq(vblank_irq), .vmatch_irq(vmatch_irq), .frame_end(frame_end));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at n=%0d: actual=%h expected=%h", req, n, act, exp);
    end
  endtask

  task automatic tick(int k);
    repeat (k) begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n = 0;
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] flags(int line, int h, int cmp);
    logic [15:0] f;
    f = '0;
    f[0] = line >= 192 && line < 262;
    f[1] = h >= HB;
    f[2] = line == cmp;
    return f;
  endfunction

  function automatic logic [15:0] masked(logic [15:0] old, logic [15:0] d);
    return (old & 16'h0047) | (d & 16'hFFB8);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd7);
    do_reset();
    // R1 reset state
    chk("R1 stat0", stat0, 0);
    chk("R1 stat1", stat1, 0);
    chk("R1 vcount", vcount, 0);
    chk("R1 pulses", {hblank_irq, vblank_irq, vmatch_irq, frame_end}, 0);

    // Free-running frame: copy 0 all enables, compare 5; copy 1 vblank enable, compare 256
    wr(2'd0, 16'h0538);
    wr(2'd1, 16'h0088);
    while (n < FRAME + 300) begin
      int line, h;
      line = (n / L) % FL;
      h = n % L;
      chk("R2 vcount", vcount, line);
      chk("R3/R4/R5/R7 stat0", stat0, 16'h0538 | flags(line, h, 5));
      chk("R3/R4/R5/R7 stat1", stat1, 16'h0088 | flags(line, h, 256));
      chk("R6 hblank_irq", hblank_irq, {1'b0, h == HB});
      chk("R6 vblank_irq", vblank_irq, {2{line == 192 && h == 0}});
      chk("R6 vmatch_irq", vmatch_irq, {1'b0, line == 5 && h == 0});
      chk("R10 frame_end", frame_end, n >= FRAME && line == 0 && h == 0);
      tick(1);
    end

    // Random status writes to copy 1 or the unused address, placed mid-line
    do_reset();
    for (int k = 0; k < 40; k++) begin
      logic [15:0] d, p0, p1;
      logic [8:0]  pv;
      logic [1:0]  a;
      while ((n % L) < 2 || (n % L) > 10) tick(1);
      d = 16'($urandom);
      a = ($urandom % 2 == 0) ? 2'd1 : 2'd3;
      p0 = stat0;
      p1 = stat1;
      pv = vcount;
      wr(a, d);
      if (a == 2'd1) begin
        chk("R7 masked write", stat1, masked(p1, d));
        chk("R7 other copy", stat0, p0);
      end else begin
        chk("R7 addr3 stat1", stat1, p1);
        chk("R7 addr3 stat0", stat0, p0);
        chk("R7 addr3 vcount", vcount, pv);
      end
      tick(($urandom % 3) * L + 5);
    end

    // Deferred line counter writes
    do_reset();
    tick(30);
    wr(2'd2, 16'd100);
    chk("R8 held", vcount, 1);
    tick(39 - n);
    chk("R8 held to line end", vcount, 1);
    tick(1);
    chk("R8 loaded", vcount, 100);
    tick(60 - n);
    chk("R8 increments after load", vcount, 101);
    tick(65 - n);
    wr(2'd2, 16'd262);
    tick(80 - n);
    chk("R8 load last line", vcount, 262);
    tick(85 - n);
    wr(2'd2, 16'd7);
    tick(100 - n);
    chk("R9 wrap forces zero", vcount, 0);
    chk("R10 frame_end after jump", frame_end, 1);
    tick(1);
    chk("R10 frame_end one cycle", frame_end, 0);
    tick(120 - n);
    chk("R9 pending dropped", vcount, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule